// File: doc/BRIEF.md
# Software Write Protection Sequencer

This block watches every completed write that the page-load front end of a byte-wide nonvolatile memory hands to it. Each write arrives as one cycle of `wr_valid` together with an address and a data byte. The block recognises fixed multi-write command codes and holds a protection flag. In the same cycle as each write, it decides whether the array may store that byte (`commit`). It also says whether the byte was consumed as a command step (`is_cmd`). Command steps are never stored.

When protection is off, ordinary writes go straight through. A three-write code turns protection on, and the flag takes effect at once, whether or not any data follows. While protection is on, the same three-write code must come before every write burst. The unlock it gives lasts only as long as the writes keep arriving inside the load window. A six-write code turns protection off.

The protection flag models nonvolatile state. It is cleared only by the factory reset `ship_rst_n`, which gives the shipped, unprotected state, and by the disable code. The power reset `pwr_rst_n` drops any half-entered sequence or open burst and leaves the flag as it is.

FSM states: `S_IDLE` (no sequence in progress), `S_ARM1` (first code write seen), `S_ARM2` (second code write seen), `S_OFF3`, `S_OFF4` and `S_OFF5` (third, fourth and fifth writes of the disable code seen), and `S_OPEN` (unlocked burst).

FSM transitions:
- `S_IDLE` moves to `S_ARM1` on AA to 5555h.
- `S_ARM1` moves to `S_ARM2` on 55 to 2AAAh.
- `S_ARM2` moves to `S_OPEN` and sets protection on A0 to 5555h, or moves to `S_OFF3` on 80 to 5555h.
- `S_OFF3` moves to `S_OFF4` on AA to 5555h.
- `S_OFF4` moves to `S_OFF5` on 55 to 2AAAh.
- `S_OFF5` returns to `S_IDLE` and clears protection on 20 to 5555h.
- Any non-matching write in a code state returns to `S_IDLE` (abort).
- Window expiry returns every non-idle state to `S_IDLE`.
- `S_OPEN` stays in `S_OPEN` on each write.

Top module: `swp_seq`

## Requirements
- R1: After `ship_rst_n`, `prot` is 0, and a write that is not a command step gives `commit`=1.
- R2: While `prot`=0 and no sequence is in progress, any write other than data AA to address 5555h gives `commit`=1 and `is_cmd`=0. This includes other data values at 5555h.
- R3: The writes AA to 5555h, 55 to 2AAAh and A0 to 5555h, in that order, each give `is_cmd`=1 and `commit`=0. `prot` reads 1 from the cycle after the third write, even if no data write follows.
- R4: While `prot`=1 and no unlock is open, a write that is not a command step gives `commit`=0 and `is_cmd`=0, and `prot` stays 1.
- R5: After the three-write unlock, each data write gives `commit`=1 as long as it comes no more than LOAD_WIN cycles after the previous write. After a gap of more than LOAD_WIN cycles, writes are discarded again.
- R6: The six writes AA to 5555h, 55 to 2AAAh, 80 to 5555h, AA to 5555h, 55 to 2AAAh and 20 to 5555h each give `is_cmd`=1. `prot` reads 0 from the cycle after the sixth, and later writes commit.
- R7: A write that does not match the expected next step ends the sequence. That write is handled as an ordinary write (`commit`= not `prot`, `is_cmd`=0), and the next code must start again from its first step.
- R8: If two consecutive command steps are more than LOAD_WIN cycles apart, the sequence is dropped, and the late step is handled as an ordinary write.
- R9: `pwr_rst_n` low drops any partial sequence and any open burst, but leaves `prot` unchanged.
- R10: `commit` and `is_cmd` are 0 in cycles without `wr_valid`, and they are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| ship_rst_n | input | 1 | Synchronous factory reset, active low; clears everything, including protection |
| pwr_rst_n | input | 1 | Synchronous power reset, active low; clears sequence and window only |
| wr_valid | input | 1 | One cycle per completed write |
| wr_addr | input | ADDR_W | Address of the write |
| wr_data | input | DATA_W | Data byte of the write |
| commit | output | 1 | Write may be stored into the array (same cycle) |
| is_cmd | output | 1 | Write was consumed as a command step (same cycle) |
| prot | output | 1 | Protection flag |

## Verification
The hardest conditions to reach from the ports are the window edges. One is a write that lands exactly LOAD_WIN cycles after the previous one. The other is a write that lands one cycle later, both in a command sequence and in an open burst. The bench shrinks LOAD_WIN to a small value and places writes at exactly those offsets. It also asserts a power reset in the middle of an unlock and inside an open burst, to show that the flag survives while the burst is closed.

// File: rtl/swp_pkg.sv
package swp_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ARM1,
        S_ARM2,
        S_OFF3,
        S_OFF4,
        S_OFF5,
        S_OPEN
    } seq_state_t;

    typedef struct packed {
        logic aa;
        logic h55;
        logic a0;
        logic h80;
        logic h20;
    } step_hit_t;
endpackage

// File: rtl/swp_match.sv
module swp_match #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR_A = 16'h5555,
    parameter logic [ADDR_W-1:0] KEY_ADDR_B = 16'h2AAA,
    parameter logic [DATA_W-1:0] CODE_OPEN  = 8'hAA,
    parameter logic [DATA_W-1:0] CODE_ECHO  = 8'h55,
    parameter logic [DATA_W-1:0] CODE_LOCK  = 8'hA0,
    parameter logic [DATA_W-1:0] CODE_ERASE = 8'h80,
    parameter logic [DATA_W-1:0] CODE_FREE  = 8'h20
) (
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     data,
    output swp_pkg::step_hit_t    hit
);
    logic at_a, at_b;

    always_comb begin
        at_a    = (addr == KEY_ADDR_A);
        at_b    = (addr == KEY_ADDR_B);
        hit.aa  = at_a && (data == CODE_OPEN);
        hit.h55 = at_b && (data == CODE_ECHO);
        hit.a0  = at_a && (data == CODE_LOCK);
        hit.h80 = at_a && (data == CODE_ERASE);
        hit.h20 = at_a && (data == CODE_FREE);
    end
endmodule

// File: rtl/swp_win_timer.sv
module swp_win_timer #(
    parameter int LOAD_WIN = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic kick,
    output logic expire
);
    localparam int CNT_W = $clog2(LOAD_WIN + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_WIN - 1);

    logic [CNT_W-1:0] cnt_q;

    assign expire = run && !kick && (cnt_q == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (kick || !run || expire) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R5
endmodule

// File: rtl/swp_seq.sv
module swp_seq #(
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 8,
    parameter int LOAD_WIN = 5000
) (
    input  logic              clk,
    input  logic              ship_rst_n,
    input  logic              pwr_rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              commit,
    output logic              is_cmd,
    output logic              prot
);
    import swp_pkg::*;

    seq_state_t state_q, state_d;
    logic       prot_q, prot_d;
    step_hit_t  hit;
    logic       expire;
    logic       seq_rst_n;

    assign seq_rst_n = ship_rst_n && pwr_rst_n;
    assign prot      = prot_q;

    swp_match #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_match (
        .addr (wr_addr),
        .data (wr_data),
        .hit  (hit)
    );

    swp_win_timer #(.LOAD_WIN(LOAD_WIN)) u_win (
        .clk    (clk),
        .rst_n  (seq_rst_n),
        .run    (state_q != S_IDLE),
        .kick   (wr_valid),
        .expire (expire)
    );

    // State register: sequence state dies with either reset, flag only with factory reset
    always_ff @(posedge clk) begin
        if (!seq_rst_n) state_q <= S_IDLE;
        else            state_q <= state_d;
        if (!ship_rst_n) prot_q <= 1'b0;
        else             prot_q <= prot_d;
    end

    always_comb begin
        state_d = state_q;
        prot_d  = prot_q;
        if (wr_valid) begin
            unique case (state_q)
                S_IDLE: if (hit.aa) state_d = S_ARM1;
                S_ARM1: state_d = hit.h55 ? S_ARM2 : S_IDLE;
                S_ARM2: begin
                    if (hit.a0) begin
                        state_d = S_OPEN;
                        prot_d  = 1'b1;
                    end else if (hit.h80) begin
                        state_d = S_OFF3;
                    end else begin
                        state_d = S_IDLE;
                    end
                end
                S_OFF3: state_d = hit.aa  ? S_OFF4 : S_IDLE;
                S_OFF4: state_d = hit.h55 ? S_OFF5 : S_IDLE;
                S_OFF5: begin
                    state_d = S_IDLE;
                    if (hit.h20) prot_d = 1'b0;
                end
                S_OPEN: state_d = S_OPEN;
                default: state_d = S_IDLE;
            endcase
        end else if (expire) begin
            state_d = S_IDLE;
        end
    end

    // Output decode
    always_comb begin
        commit = 1'b0;
        is_cmd = 1'b0;
        if (wr_valid) begin
            unique case (state_q)
                S_IDLE: if (hit.aa) is_cmd = 1'b1; else commit = !prot_q;
                S_ARM1: if (hit.h55) is_cmd = 1'b1; else commit = !prot_q;
                S_ARM2: if (hit.a0 || hit.h80) is_cmd = 1'b1; else commit = !prot_q;
                S_OFF3: if (hit.aa) is_cmd = 1'b1; else commit = !prot_q;
                S_OFF4: if (hit.h55) is_cmd = 1'b1; else commit = !prot_q;
                S_OFF5: if (hit.h20) is_cmd = 1'b1; else commit = !prot_q;
                S_OPEN: commit = 1'b1;
                default: commit = 1'b0;
            endcase
        end
    end

    AST_QUIET_OUT: assert property (@(posedge clk) disable iff (!seq_rst_n)
        !wr_valid |-> (!commit && !is_cmd)); // R10
    AST_OUT_EXCL: assert property (@(posedge clk) disable iff (!seq_rst_n)
        $onehot0({commit, is_cmd})); // R10
    AST_LOCKED_DROP: assert property (@(posedge clk) disable iff (!seq_rst_n)
        (prot_q && state_q == S_IDLE && wr_valid && !is_cmd) |-> !commit); // R4
    AST_FLAG_QUIET: assert property (@(posedge clk) disable iff (!ship_rst_n)
        !wr_valid |=> $stable(prot_q)); // R9
    AST_SET_FROM_ARM: assert property (@(posedge clk) disable iff (!ship_rst_n)
        $rose(prot_q) |-> ($past(state_q) == S_ARM2)); // R3
    AST_CLR_FROM_OFF: assert property (@(posedge clk) disable iff (!ship_rst_n)
        $fell(prot_q) |-> ($past(state_q) == S_OFF5)); // R6
    AST_EXPIRE_IDLE: assert property (@(posedge clk) disable iff (!seq_rst_n)
        expire |=> (state_q == S_IDLE)); // R8
endmodule

// File: tb/sim_swp_seq.sv
module sim_swp_seq;
    localparam int WIN = 12;

    logic        clk = 1'b0;
    logic        ship_rst_n = 1'b0;
    logic        pwr_rst_n = 1'b1;
    logic        wr_valid = 1'b0;
    logic [15:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        commit, is_cmd, prot;

    int total = 0;
    int bad = 0;
    int ms = 0;
    bit mp = 1'b0;
    int mgap = 0;

    always #10 clk = ~clk;

    swp_seq #(.ADDR_W(16), .DATA_W(8), .LOAD_WIN(WIN)) u0 (
        .clk(clk), .ship_rst_n(ship_rst_n), .pwr_rst_n(pwr_rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit(commit), .is_cmd(is_cmd), .prot(prot)
    );

    task automatic chk(input string tag, input string what, input logic act, input bit exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%0b exp=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // model states: 0 idle,1 arm1,2 arm2,3 off3,4 off4,5 off5,6 open
    task automatic step(input bit v, input logic [15:0] a, input logic [7:0] d,
                        input bit pwr, input string tag);
        bit ec, ex, np, aa, k55, ka0, k80, k20;
        int ns;
        @(negedge clk);
        wr_valid = v; wr_addr = a; wr_data = d; pwr_rst_n = !pwr;
        #1;
        aa  = (a == 16'h5555) && (d == 8'hAA);
        k55 = (a == 16'h2AAA) && (d == 8'h55);
        ka0 = (a == 16'h5555) && (d == 8'hA0);
        k80 = (a == 16'h5555) && (d == 8'h80);
        k20 = (a == 16'h5555) && (d == 8'h20);
        ec = 0; ex = 0; ns = ms; np = mp;
        if (pwr) begin
            ns = 0; mgap = 0;
        end else if (v) begin
            mgap = 0;
            case (ms)
                0: if (aa) begin ex = 1; ns = 1; end else ec = !mp;
                1: if (k55) begin ex = 1; ns = 2; end else begin ec = !mp; ns = 0; end
                2: if (ka0) begin ex = 1; ns = 6; np = 1; end
                   else if (k80) begin ex = 1; ns = 3; end
                   else begin ec = !mp; ns = 0; end
                3: if (aa) begin ex = 1; ns = 4; end else begin ec = !mp; ns = 0; end
                4: if (k55) begin ex = 1; ns = 5; end else begin ec = !mp; ns = 0; end
                5: if (k20) begin ex = 1; ns = 0; np = 0; end else begin ec = !mp; ns = 0; end
                default: ec = 1;
            endcase
        end else if (ms != 0) begin
            mgap++;
            if (mgap >= WIN) ns = 0;
        end
        chk(tag, "commit", commit, ec);
        chk(tag, "is_cmd", is_cmd, ex);
        chk(tag, "prot", prot, mp);
        ms = ns; mp = np;
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d, input string tag);
        step(1'b1, a, d, 1'b0, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0, 8'h0, 1'b0, tag);
    endtask

    task automatic unlock(input string tag);
        wr(16'h5555, 8'hAA, tag);
        wr(16'h2AAA, 8'h55, tag);
        wr(16'h5555, 8'hA0, tag);
    endtask

    task automatic finish_up;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL R1 watchdog act=running exp=done");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        ship_rst_n = 1'b1;
        // R1: reset state
        idle(1, "R1");
        wr(16'h0010, 8'h3C, "R1");
        // R2: unprotected ordinary writes, including 5555h with other data
        wr(16'h5555, 8'h11, "R2");
        wr(16'hFFFF, 8'hAA, "R2");
        wr(16'h2AAA, 8'h55, "R2");
        idle(2, "R10");
        // R7: aborted sequences
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h0100, 8'h12, "R7");
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h2AAA, 8'h55, "R7");
        wr(16'h5555, 8'h55, "R7");
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h2AAA, 8'h55, "R7");
        // R3: enable, then burst with gaps up to the window
        unlock("R3");
        idle(1, "R3");
        wr(16'h0200, 8'h01, "R5");
        idle(WIN - 1, "R5");
        wr(16'h0201, 8'h02, "R5");
        idle(WIN, "R5");
        wr(16'h0202, 8'h03, "R5");
        idle(WIN + 1, "R5");
        // R4: lone writes discarded while protected
        wr(16'h0203, 8'h04, "R4");
        wr(16'h5555, 8'h20, "R4");
        // R7 in protected mode: mismatch discarded
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h0300, 8'h77, "R7");
        // R8: late command step
        wr(16'h5555, 8'hAA, "R8");
        idle(WIN + 1, "R8");
        wr(16'h2AAA, 8'h55, "R8");
        wr(16'h5555, 8'hA0, "R8");
        // R8: step at exactly the window still counts
        wr(16'h5555, 8'hAA, "R8");
        idle(WIN - 1, "R8");
        wr(16'h2AAA, 8'h55, "R8");
        wr(16'h5555, 8'hA0, "R8");
        wr(16'h0400, 8'h44, "R8");
        // R9: power reset inside open burst and mid unlock
        step(1'b0, 16'h0, 8'h0, 1'b1, "R9");
        wr(16'h0401, 8'h45, "R9");
        wr(16'h5555, 8'hAA, "R9");
        wr(16'h2AAA, 8'h55, "R9");
        step(1'b0, 16'h0, 8'h0, 1'b1, "R9");
        wr(16'h5555, 8'hA0, "R9");
        wr(16'h0402, 8'h46, "R9");
        // R6: disable, with gaps inside the window
        wr(16'h5555, 8'hAA, "R6");
        wr(16'h2AAA, 8'h55, "R6");
        idle(3, "R6");
        wr(16'h5555, 8'h80, "R6");
        wr(16'h5555, 8'hAA, "R6");
        idle(WIN - 1, "R6");
        wr(16'h2AAA, 8'h55, "R6");
        wr(16'h5555, 8'h20, "R6");
        idle(1, "R6");
        wr(16'h0500, 8'h50, "R6");
        // R3: enable with no data, protection effective; then R9 keeps it
        unlock("R3");
        idle(WIN + 2, "R3");
        wr(16'h0600, 8'h60, "R3");
        step(1'b0, 16'h0, 8'h0, 1'b1, "R9");
        wr(16'h0601, 8'h61, "R9");
        // R7: broken disable attempt leaves protection on
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h2AAA, 8'h55, "R7");
        wr(16'h5555, 8'h80, "R7");
        wr(16'h5555, 8'hAA, "R7");
        wr(16'h2AAA, 8'h55, "R7");
        wr(16'h5555, 8'h21, "R7");
        wr(16'h0700, 8'h70, "R7");
        idle(2, "R10");
        finish_up();
    end
endmodule